// File: doc/BRIEF.md
# DDR SDRAM Burst Access Sequencer

This block turns single host requests into the command sequence a DDR SDRAM expects on its command bus. A request names a bank, a row, a starting column, the direction, a burst length and whether the row should close by itself when the burst ends. The sequencer remembers which row is open in each of the four banks. A request that hits the open row goes straight to a column command. A request to a closed bank first opens the row. A request that conflicts with a different open row first closes the old row and then opens the new one. Command spacing is enforced from cycle-count parameters.

Commands are registered and appear on the bus one cycle after the controller decides them. A separate refresh controller can claim the bus with `refresh_own`. While it holds the bus, the sequencer stops issuing commands and refuses new requests. For reads, the block raises a two-bit data-due flag for every half-cycle in which the memory will drive read data. This timing comes from the selected CAS latency and the burst length.

The controller has four states:
- S_IDLE waits for a request. It leaves on accept to S_ACCESS on a row hit, to S_ACTIV on a closed bank, or to S_PRECH on a row conflict.
- S_PRECH issues Precharge and moves to S_ACTIV.
- S_ACTIV issues Active once the bank's precharge time has passed and moves to S_ACCESS.
- S_ACCESS issues Read or Write once the activate-to-column delay and the burst spacing allow it, and returns to S_IDLE.

Top module: `ddr_cmd_seq`

## Requirements
- R1: After reset the command bus shows NOP, `req_ready` is high (with `refresh_own` low) and `rd_due` is zero.
- R2: A request to a bank with no open row produces Active (row on `cmd_addr`, bank on `cmd_ba`), then the column command, with no Precharge.
- R3: A request whose row equals the open row of its bank produces only the column command.
- R4: A request to a bank holding a different open row produces Precharge (`cmd_addr[10]` low), then Active, then the column command. The Active comes exactly TRP cycles after the Precharge when refresh does not intervene.
- R5: A column command comes exactly TRCD cycles after the Active to the same bank when refresh and burst spacing do not intervene, and never sooner.
- R6: `{cmd_cs_n,cmd_ras_n,cmd_cas_n,cmd_we_n}` encodes NOP 0111, Active 0011, Read 0101, Write 0100 and Precharge 0010. A column command carries the column in `cmd_addr[8:0]` and the auto-precharge flag in `cmd_addr[10]`, with other bits zero.
- R7: A column command with auto-precharge leaves its bank closed. The next access to that bank starts with Active and no Precharge, issued no sooner than BL/2+TRP cycles after the column command.
- R8: Two column commands (any banks) are at least BL/2 cycles apart, where BL is the earlier burst's length. A Precharge also waits for the earlier burst to finish.
- R9: While `refresh_own` is high, `req_ready` is low and the command in the following cycle is NOP. An interrupted sequence completes after refresh releases the bus.
- R10: A Read issued in cycle 0 sets `rd_due` for half-cycle slots 2·CL through 2·CL+BL−1, where slot 2c+0 is `rd_due[0]` (rising half) and slot 2c+1 is `rd_due[1]` (falling half) of cycle c. `cl_sel` 0/1/2 selects CL 2/2.5/3. `req_bl` 0/1/2 selects BL 2/4/8.
- R11: Write commands never raise `rd_due`.
- R12: The four banks keep independent open rows, so rows left open in all four banks are each hit without further Active commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_own | input | 1 | Refresh controller holds the command bus |
| cl_sel | input | 2 | CAS latency select: 0=2, 1=2.5, 2=3 |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 9 | Starting column |
| req_bl | input | 2 | Burst length select: 0=2, 1=4, 2=8 |
| req_ap | input | 1 | Close the row after this burst |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_addr | output | 13 | Row or column address |
| rd_due | output | 2 | Read data expected in rising [0] / falling [1] half |

## Verification
The hardest situation to reach is a row-conflict sequence that refresh interrupts partway through. The Precharge-to-Active and Active-to-column gaps then stretch. The command order must still hold, and no command may leak onto the bus while refresh holds it. The stimulus first leaves a row open in bank 3. It then issues a conflicting request and raises `refresh_own` two cycles later for several cycles, so the pause lands between commands of the sequence. A second hard case is the half-cycle read-data window at CL 2.5 after back-to-back row hits. This is reached by changing `cl_sel` while the bus is idle and then issuing row hits of different burst lengths.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        C_NOP = 4'b0111,
        C_ACT = 4'b0011,
        C_RD  = 4'b0101,
        C_WR  = 4'b0100,
        C_PRE = 4'b0010
    } cmd_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PRECH,
        S_ACTIV,
        S_ACCESS
    } seq_state_e;

    function automatic int unsigned burst_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd1:    return 4;
            default: return 8;
        endcase
    endfunction

    // first data slot in half-cycles after the read command
    function automatic int unsigned first_slot(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4;
            2'd1:    return 5;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/ddr_bank_track.sv
module ddr_bank_track #(
    parameter int BANKS = 4,
    parameter int ROW_W = 13,
    parameter int CNT_W = 4,
    parameter int TRCD  = 3,
    parameter int TRP   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        act_fire,
    input  logic                        pre_fire,
    input  logic                        col_fire,
    input  logic                        col_ap,
    input  logic [$clog2(BANKS)-1:0]    cmd_bank,
    input  logic [ROW_W-1:0]            act_row,
    input  logic [CNT_W-1:0]            ap_wait,
    output logic [BANKS-1:0]            bank_open,
    output logic [BANKS-1:0][ROW_W-1:0] bank_row,
    output logic [BANKS-1:0]            rcd_done,
    output logic [BANKS-1:0]            rp_done
);
    localparam int BA_W = $clog2(BANKS);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        logic [CNT_W-1:0] rcd_q;
        logic [CNT_W-1:0] rp_q;
        logic             sel;

        assign sel = (cmd_bank == BA_W'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
                rcd_q  <= '0;
                rp_q   <= '0;
            end else begin
                if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
                if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
                if (sel && act_fire) begin
                    open_q <= 1'b1;
                    row_q  <= act_row;
                    rcd_q  <= CNT_W'(TRCD - 1);
                end
                if (sel && pre_fire) begin
                    open_q <= 1'b0;
                    rp_q   <= CNT_W'(TRP - 1);
                end
                if (sel && col_fire && col_ap) begin
                    open_q <= 1'b0;
                    rp_q   <= ap_wait;
                end
            end
        end

        assign bank_open[b] = open_q;
        assign bank_row[b]  = row_q;
        assign rcd_done[b]  = (rcd_q == '0);
        assign rp_done[b]   = (rp_q == '0);

        // column only into an open row whose activate delay has run out
        assert_col_rcd_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (col_fire && sel) |-> (open_q && rcd_q == '0));

        // activate only into a closed bank whose precharge time has run out
        assert_act_rp_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (act_fire && sel) |-> (!open_q && rp_q == '0));
    end

endmodule

// File: rtl/ddr_rd_window.sv
module ddr_rd_window
    import ddr_seq_pkg::*;
#(
    parameter int MAX_BL = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_fire,
    input  logic [1:0] cl_sel,
    input  logic [1:0] bl_sel,
    output logic [1:0] rd_due
);
    localparam int SLOTS = 6 + MAX_BL;

    logic [SLOTS-1:0] slot_q;
    logic [SLOTS-1:0] load_mask;
    logic [SLOTS-1:0] shifted;

    always_comb begin
        int unsigned lo;
        int unsigned hi;
        lo = first_slot(cl_sel);
        hi = lo + burst_len(bl_sel);
        for (int h = 0; h < SLOTS; h++) begin
            load_mask[h] = rd_fire && (h >= lo) && (h < hi);
        end
    end

    assign shifted = slot_q >> 2;

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= shifted | load_mask;
    end

    assign rd_due = slot_q[1:0];

    // a new read window must not collide with one still in flight
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |-> ((shifted & load_mask) == '0));

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
    import ddr_seq_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10,
    parameter int TRCD   = 3,
    parameter int TRP    = 3,
    parameter int MAX_BL = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     refresh_own,
    input  logic [1:0]               cl_sel,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [$clog2(BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [COL_W-1:0]         req_col,
    input  logic [1:0]               req_bl,
    input  logic                     req_ap,
    output logic                     cmd_cs_n,
    output logic                     cmd_ras_n,
    output logic                     cmd_cas_n,
    output logic                     cmd_we_n,
    output logic [$clog2(BANKS)-1:0] cmd_ba,
    output logic [ADDR_W-1:0]        cmd_addr,
    output logic [1:0]               rd_due
);
    localparam int BA_W  = $clog2(BANKS);
    localparam int CNT_W = $clog2(MAX_BL / 2 + TRP + TRCD + 2);

    seq_state_e state_q, state_d;

    logic             q_write, q_ap;
    logic [BA_W-1:0]  q_bank;
    logic [ROW_W-1:0] q_row;
    logic [COL_W-1:0] q_col;
    logic [1:0]       q_bl;

    logic act_fire, pre_fire, col_fire;
    logic [CNT_W-1:0] gap_q, half_bl, ap_wait;
    logic [ADDR_W-1:0] col_addr;
    cmd_e cmd_q;

    logic [BANKS-1:0]            bank_open, rcd_done, rp_done;
    logic [BANKS-1:0][ROW_W-1:0] bank_row;

    assign req_ready = (state_q == S_IDLE) && !refresh_own;
    assign half_bl   = CNT_W'(burst_len(q_bl) / 2);
    assign ap_wait   = half_bl + CNT_W'(TRP - 1);

    ddr_bank_track #(
        .BANKS(BANKS), .ROW_W(ROW_W), .CNT_W(CNT_W), .TRCD(TRCD), .TRP(TRP)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .act_fire(act_fire), .pre_fire(pre_fire), .col_fire(col_fire),
        .col_ap(q_ap), .cmd_bank(q_bank), .act_row(q_row), .ap_wait(ap_wait),
        .bank_open(bank_open), .bank_row(bank_row),
        .rcd_done(rcd_done), .rp_done(rp_done)
    );

    ddr_rd_window #(.MAX_BL(MAX_BL)) u_rdwin (
        .clk(clk), .rst_n(rst_n),
        .rd_fire(col_fire && !q_write),
        .cl_sel(cl_sel), .bl_sel(q_bl),
        .rd_due(rd_due)
    );

    // next state and command decision
    always_comb begin
        state_d  = state_q;
        act_fire = 1'b0;
        pre_fire = 1'b0;
        col_fire = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid && req_ready) begin
                    if (!bank_open[req_bank])                 state_d = S_ACTIV;
                    else if (bank_row[req_bank] == req_row)   state_d = S_ACCESS;
                    else                                      state_d = S_PRECH;
                end
            end
            S_PRECH: begin
                if (!refresh_own && gap_q == '0) begin
                    pre_fire = 1'b1;
                    state_d  = S_ACTIV;
                end
            end
            S_ACTIV: begin
                if (!refresh_own && rp_done[q_bank]) begin
                    act_fire = 1'b1;
                    state_d  = S_ACCESS;
                end
            end
            S_ACCESS: begin
                if (!refresh_own && rcd_done[q_bank] && gap_q == '0) begin
                    col_fire = 1'b1;
                    state_d  = S_IDLE;
                end
            end
        endcase
    end

    // state register, request latch and burst spacing counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            q_write <= 1'b0;
            q_ap    <= 1'b0;
            q_bank  <= '0;
            q_row   <= '0;
            q_col   <= '0;
            q_bl    <= '0;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid && req_ready) begin
                q_write <= req_write;
                q_ap    <= req_ap;
                q_bank  <= req_bank;
                q_row   <= req_row;
                q_col   <= req_col;
                q_bl    <= req_bl;
            end
            if (col_fire)           gap_q <= half_bl - 1'b1;
            else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
        end
    end

    always_comb begin
        col_addr              = '0;
        col_addr[COL_W-1:0]   = q_col;
        col_addr[AP_BIT]      = q_ap;
    end

    // registered command bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= C_NOP;
            cmd_ba   <= '0;
            cmd_addr <= '0;
        end else begin
            cmd_q <= C_NOP;
            if (act_fire) begin
                cmd_q    <= C_ACT;
                cmd_ba   <= q_bank;
                cmd_addr <= ADDR_W'(q_row);
            end else if (pre_fire) begin
                cmd_q    <= C_PRE;
                cmd_ba   <= q_bank;
                cmd_addr <= '0;
            end else if (col_fire) begin
                cmd_q    <= q_write ? C_WR : C_RD;
                cmd_ba   <= q_bank;
                cmd_addr <= col_addr;
            end
        end
    end

    assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;

    // refresh ownership silences the bus on the following cycle
    assert_refresh_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_own |=> ({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b0111));

    // a column command only lands in the row that the tracker holds open
    assert_hit_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_fire |-> (bank_open[q_bank] && bank_row[q_bank] == q_row));

endmodule

// File: tb/ddr_cmd_seq_test.sv
module ddr_cmd_seq_test;

    localparam int TRCD = 3;
    localparam int TRP  = 3;
    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_ACT = 4'b0011;
    localparam logic [3:0] K_RD  = 4'b0101;
    localparam logic [3:0] K_WR  = 4'b0100;
    localparam logic [3:0] K_PRE = 4'b0010;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic [1:0]  bl;
        logic        ap;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refresh_own = 1'b0;
    logic [1:0] cl_sel = 2'd0;
    logic req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
    logic [1:0] req_bank = '0, req_bl = '0;
    logic [12:0] req_row = '0;
    logic [8:0] req_col = '0;
    logic req_ready, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [1:0] cmd_ba, rd_due;
    logic [12:0] cmd_addr;

    always #5 clk = ~clk;

    ddr_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .refresh_own(refresh_own), .cl_sel(cl_sel),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_bl(req_bl), .req_ap(req_ap),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .rd_due(rd_due)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_refresh = -100;
    exp_t sbq[$];
    logic [1:0] exp_due [0:8191];
    logic       m_open [0:3];
    logic [12:0] m_row [0:3];
    logic [3:0] lk_kind [0:3];
    int         lk_cyc [0:3];
    logic [1:0] lk_bl [0:3];
    logic       lk_ap [0:3];
    int         lcol_cyc = -100;
    logic [1:0] lcol_bl = 2'd0;

    function automatic int blen(input logic [1:0] s);
        return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop, spacing and read window checks
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] k;
            k = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
            if (refresh_own) begin
                last_refresh = cyc;
                check(k == K_NOP, "R9", "bus not NOP under refresh", int'(k), int'(K_NOP));
            end
            if (k != K_NOP) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R6", "unexpected command", int'(k), 0);
                end else begin
                    exp_t e;
                    int b;
                    e = sbq.pop_front();
                    b = int'(cmd_ba);
                    check(k == e.cmd, "R6", "command code", int'(k), int'(e.cmd));
                    check(cmd_ba == e.ba, "R6", "bank", int'(cmd_ba), int'(e.ba));
                    check(cmd_addr == e.addr, "R6", "address", int'(cmd_addr), int'(e.addr));
                    if (k == K_ACT && lk_kind[b] == K_PRE) begin
                        if (last_refresh > lk_cyc[b])
                            check(cyc - lk_cyc[b] >= TRP, "R4", "PRE->ACT gap", cyc - lk_cyc[b], TRP);
                        else
                            check(cyc - lk_cyc[b] == TRP, "R4", "PRE->ACT gap", cyc - lk_cyc[b], TRP);
                    end
                    if (k == K_ACT && (lk_kind[b] == K_RD || lk_kind[b] == K_WR) && lk_ap[b])
                        check(cyc - lk_cyc[b] >= blen(lk_bl[b]) / 2 + TRP, "R7",
                              "auto-precharge to ACT gap", cyc - lk_cyc[b], blen(lk_bl[b]) / 2 + TRP);
                    if (k == K_RD || k == K_WR) begin
                        if (lk_kind[b] == K_ACT) begin
                            if (last_refresh > lk_cyc[b])
                                check(cyc - lk_cyc[b] >= TRCD, "R5", "ACT->col gap", cyc - lk_cyc[b], TRCD);
                            else
                                check(cyc - lk_cyc[b] == TRCD, "R5", "ACT->col gap", cyc - lk_cyc[b], TRCD);
                        end
                        check(cyc - lcol_cyc >= blen(lcol_bl) / 2, "R8", "col->col gap",
                              cyc - lcol_cyc, blen(lcol_bl) / 2);
                        lcol_cyc = cyc;
                        lcol_bl  = e.bl;
                        lk_bl[b] = e.bl;
                        lk_ap[b] = e.ap;
                    end
                    if (k == K_PRE)
                        check(cyc - lcol_cyc >= blen(lcol_bl) / 2, "R8", "col->PRE gap",
                              cyc - lcol_cyc, blen(lcol_bl) / 2);
                    if (k == K_RD) begin
                        int first;
                        first = (cl_sel == 2'd0) ? 4 : (cl_sel == 2'd1) ? 5 : 6;
                        for (int h = first; h < first + blen(e.bl); h++)
                            exp_due[cyc + h / 2][h % 2] = 1'b1;
                    end
                    lk_kind[b] = k;
                    lk_cyc[b]  = cyc;
                end
            end
            // R10 read window, R11 writes leave it clear
            if (rd_due != 2'b00 || exp_due[cyc] != 2'b00)
                check(rd_due == exp_due[cyc], "R10 R11", "rd_due", int'(rd_due), int'(exp_due[cyc]));
            cyc++;
        end
    end

    task automatic do_req(input logic w, input logic [1:0] b, input logic [12:0] row,
                          input logic [8:0] col, input logic [1:0] bl, input logic ap);
        exp_t e;
        logic [12:0] ca;
        ca = 13'(col);
        ca[10] = ap;
        if (m_open[b] && m_row[b] != row) begin
            e = '{cmd: K_PRE, ba: b, addr: 13'd0, bl: bl, ap: 1'b0};
            sbq.push_back(e);
        end
        if (!m_open[b] || m_row[b] != row) begin
            e = '{cmd: K_ACT, ba: b, addr: row, bl: bl, ap: 1'b0};
            sbq.push_back(e);
        end
        e = '{cmd: (w ? K_WR : K_RD), ba: b, addr: ca, bl: bl, ap: ap};
        sbq.push_back(e);
        m_open[b] = !ap;
        m_row[b]  = row;
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = w; req_bank = b; req_row = row;
        req_col = col; req_bl = bl; req_ap = ap;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int n;
        n = 0;
        while ((sbq.size() != 0 || !req_ready) && n < 200) begin @(negedge clk); n++; end
        repeat (12) @(negedge clk);
        check(sbq.size() == 0, req, "pending expected commands", sbq.size(), 0);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8192; i++) exp_due[i] = 2'b00;
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 1'b0; m_row[i] = '0; lk_kind[i] = K_NOP;
            lk_cyc[i] = -100; lk_bl[i] = '0; lk_ap[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R1 reset state
        check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == K_NOP, "R1", "bus at reset",
              int'({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}), int'(K_NOP));
        check(req_ready == 1'b1, "R1", "ready at reset", int'(req_ready), 1);
        check(rd_due == 2'b00, "R1", "rd_due at reset", int'(rd_due), 0);
        #1 rst_n = 1'b1;

        // R2 closed bank read, then R3 hit and R8 spacing back to back
        do_req(1'b0, 2'd0, 13'h055, 9'h008, 2'd1, 1'b0);
        do_req(1'b0, 2'd0, 13'h055, 9'h010, 2'd2, 1'b0);
        drain("R3");
        // R11 write to closed bank
        do_req(1'b1, 2'd1, 13'h100, 9'h004, 2'd0, 1'b0);
        drain("R11");
        // R12 fill all banks, then hit each
        do_req(1'b0, 2'd2, 13'h007, 9'h020, 2'd0, 1'b0);
        do_req(1'b0, 2'd3, 13'h009, 9'h030, 2'd1, 1'b0);
        do_req(1'b1, 2'd1, 13'h100, 9'h044, 2'd2, 1'b0);
        do_req(1'b0, 2'd2, 13'h007, 9'h050, 2'd0, 1'b0);
        do_req(1'b0, 2'd3, 13'h009, 9'h060, 2'd1, 1'b0);
        do_req(1'b0, 2'd0, 13'h055, 9'h070, 2'd0, 1'b0);
        drain("R12");
        // R4 row conflict
        do_req(1'b0, 2'd0, 13'h0AA, 9'h001, 2'd0, 1'b0);
        drain("R4");
        // R10 half-cycle latency and CL3
        cl_sel = 2'd1;
        do_req(1'b0, 2'd0, 13'h0AA, 9'h002, 2'd1, 1'b0);
        do_req(1'b0, 2'd0, 13'h0AA, 9'h003, 2'd0, 1'b0);
        drain("R10");
        cl_sel = 2'd2;
        do_req(1'b0, 2'd0, 13'h0AA, 9'h004, 2'd2, 1'b0);
        drain("R10");
        cl_sel = 2'd0;
        // R7 auto-precharge then reopen same row
        do_req(1'b0, 2'd2, 13'h007, 9'h0F0, 2'd2, 1'b1);
        do_req(1'b0, 2'd2, 13'h007, 9'h0F8, 2'd1, 1'b0);
        drain("R7");
        // R9 refresh lands inside a conflict sequence
        fork
            do_req(1'b0, 2'd3, 13'h1FF, 9'h011, 2'd1, 1'b0);
            begin
                @(negedge clk); @(negedge clk); #1;
                refresh_own = 1'b1;
                @(negedge clk);
                check(req_ready == 1'b0, "R9", "ready under refresh", int'(req_ready), 0);
                repeat (5) @(negedge clk);
                #1 refresh_own = 1'b0;
            end
        join
        drain("R9");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule